// File: doc/BRIEF.md
# Scaled Binary-to-BCD Tracking Converter

This block turns an 8-bit unsigned sample (0 to 255) into a four-digit packed BCD number proportional to it, spanning 0 to 8988. It has no divider and no shift-and-add conversion. The sample is multiplied by the constant 141 and the two lowest product bits are dropped. The result is a 14-bit binary target, about one part in a thousand from the exact 9000/255 scaling. For example, 0x80 gives 4512.

Two counters step together on the same clock: a binary up/down counter and a BCD up/down counter. They share one reset and one direction, so the BCD digits always spell the decimal value of the binary count. A comparator looks at the binary count and the target. While they differ it steps both counters one unit toward the target, and when they agree it holds them and raises a settled flag.

The target is registered from the input on every clock. A changed input makes the counters walk from wherever they are. The worst case, from 0 to full scale, takes 8988 clocks. The block suits slowly changing quantities that are shown in decimal.

Top module: `bcd_track_conv`

## Requirements
- R1: On every clock edge out of reset the target register loads (din * 141) >> 2. Once settled, the BCD output equals that value in decimal; for example, din = 0x80 settles at 16'h4512.
- R2: A clock edge with rst_n low clears the binary count, the BCD digits and the target. After such an edge, bcd reads 16'h0000 and settled reads 1.
- R3: When the binary count is below the target, both counters rise by exactly one on each clock edge.
- R4: When the binary count is above the target, both counters fall by exactly one on each clock edge.
- R5: When the count equals the target, both counters hold and settled is 1; at all other times settled is 0.
- R6: bcd holds digit i in bits [4i+3:4i], with digit 0 the units. The decimal value it spells always equals the binary count.
- R7: Every digit stays within 0 to 9. Counting up from 9, a digit wraps to 0 and carries into the next digit (0999 to 1000). Counting down from 0, a digit wraps to 9 and borrows (1000 to 0999).
- R8: An input change while the counters are moving does not restart them from zero; they keep stepping from the present count toward the new target.
- R9: The count never exceeds 8988, and from 0 a full-scale input settles within 8990 clocks.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| din | input | 8 | Unsigned sample to scale |
| bcd | output | 16 | Four packed BCD digits, units in bits [3:0] |
| settled | output | 1 | High when the count equals the target |

## Verification
The hardest cases to reach from the ports are a carry or borrow that ripples through three digits at once. These are the step between 0999 and 1000 in either direction. Inputs 28 and 29 have targets of 987 and 1022, which lie on either side of that boundary, so the stimulus walks the count across it both ways and watches the exact cycle of the ripple. A second hard case is a new input arriving mid-walk. The bench changes the input partway through a long descent and expects the count to carry on from its present value rather than from zero. A per-cycle model of the count checks every step and direction in between.

// File: rtl/bcd_track_pkg.sv
// Package: shared types for the scaled tracking converter.
// Assumes: the step direction is a three-valued decision made once per clock.
package bcd_track_pkg;

    // One packed BCD digit.
    typedef logic [3:0] bcd_digit_t;

    // Direction both counters take on the next clock edge.
    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_e;

endpackage

// File: rtl/bct_bcd_digit.sv
// Module: one decimal digit of the up/down BCD counter.
// Does: when enabled, moves one unit up or down, wrapping 9->0 or 0->9.
// Assumes: the caller works out the enable from the lower digits' wrap.
module bct_bcd_digit
    import bcd_track_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       up,
    output bcd_digit_t digit_q
);

    // Digit register: clear on reset, step with wrap when enabled.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            digit_q <= 4'd0;
        end else if (en) begin
            if (up) begin
                digit_q <= (digit_q == 4'd9) ? 4'd0 : digit_q + 4'd1;
            end else begin
                digit_q <= (digit_q == 4'd0) ? 4'd9 : digit_q - 4'd1;
            end
        end
    end

endmodule

// File: rtl/bct_scale.sv
// Module: constant-multiply scaler that forms the binary target.
// Does: registers (din * SCALE) >> DROP on every clock.
// Assumes: SCALE fits in SCALE_W bits; the product is unsigned.
module bct_scale #(
    parameter int IN_W    = 8,
    parameter int SCALE_W = 8,
    parameter int SCALE   = 141,
    parameter int DROP    = 2
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [IN_W-1:0]               din,
    output logic [IN_W+SCALE_W-DROP-1:0]  tgt_q
);

    localparam int PROD_W = IN_W + SCALE_W;

    logic [PROD_W-1:0] prod;

    // Full-width unsigned product of the sample and the constant.
    always_comb begin
        prod = PROD_W'(din) * PROD_W'(SCALE);
    end

    // Target register: keep the upper product bits, clear on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            tgt_q <= '0;
        end else begin
            tgt_q <= prod[PROD_W-1:DROP];
        end
    end

endmodule

// File: rtl/bct_bin_counter.sv
// Module: binary up/down counter that follows the step decision.
// Does: adds one, subtracts one or holds, per the shared step.
// Assumes: the comparator never asks to step beyond the target range.
module bct_bin_counter
    import bcd_track_pkg::*;
#(
    parameter int W = 14
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_e        step,
    output logic [W-1:0] cnt_q
);

    // Count register: clear on reset, otherwise step as directed.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            case (step)
                STEP_UP:   cnt_q <= cnt_q + W'(1);
                STEP_DOWN: cnt_q <= cnt_q - W'(1);
                default:   cnt_q <= cnt_q;
            endcase
        end
    end

endmodule

// File: rtl/bct_bcd_counter.sv
// Module: multi-digit BCD up/down counter driven by the shared step.
// Does: steps the units digit, rippling wrap enables into higher digits.
// Assumes: the count never wraps past all nines or below zero.
module bct_bcd_counter
    import bcd_track_pkg::*;
#(
    parameter int DIGITS = 4
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  step_e                 step,
    output logic [4*DIGITS-1:0]   bcd_q
);

    logic              up;
    logic [DIGITS-1:0] ripple;

    // Direction and units enable from the shared step.
    always_comb begin
        up        = (step == STEP_UP);
        ripple[0] = (step != STEP_HOLD);
    end

    for (genvar g = 0; g < DIGITS; g++) begin : g_digit
        bct_bcd_digit u_digit (
            .clk     (clk),
            .rst_n   (rst_n),
            .en      (ripple[g]),
            .up      (up),
            .digit_q (bcd_q[4*g +: 4])
        );
        if (g < DIGITS - 1) begin : g_pass
            // Next digit moves only when this one moves and wraps.
            assign ripple[g+1] = ripple[g] &
                (up ? (bcd_q[4*g +: 4] == 4'd9) : (bcd_q[4*g +: 4] == 4'd0));
        end
    end

endmodule

// File: rtl/bcd_track_conv.sv
// Module: scaled binary-to-BCD tracking converter (top).
// Does: scales din into a binary target, then walks twin binary and BCD
//       counters one step per clock until the binary count meets it.
// Assumes: DIGITS decimal digits can hold the largest target.
module bcd_track_conv
    import bcd_track_pkg::*;
#(
    parameter int IN_W    = 8,
    parameter int SCALE_W = 8,
    parameter int SCALE   = 141,
    parameter int DROP    = 2,
    parameter int DIGITS  = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [IN_W-1:0]      din,
    output logic [4*DIGITS-1:0]  bcd,
    output logic                 settled
);

    localparam int TGT_W   = IN_W + SCALE_W - DROP;
    localparam int MAX_TGT = (((1 << IN_W) - 1) * SCALE) >> DROP;

    logic [TGT_W-1:0] tgt_q;
    logic [TGT_W-1:0] bin_q;
    step_e            step;

    bct_scale #(
        .IN_W    (IN_W),
        .SCALE_W (SCALE_W),
        .SCALE   (SCALE),
        .DROP    (DROP)
    ) u_scale (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (din),
        .tgt_q (tgt_q)
    );

    // Comparator: pick the step that moves the count toward the target.
    always_comb begin
        if (bin_q < tgt_q) begin
            step = STEP_UP;
        end else if (bin_q > tgt_q) begin
            step = STEP_DOWN;
        end else begin
            step = STEP_HOLD;
        end
    end

    // Settled whenever the comparator chooses to hold.
    assign settled = (step == STEP_HOLD);

    bct_bin_counter #(
        .W (TGT_W)
    ) u_bin (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .cnt_q (bin_q)
    );

    bct_bcd_counter #(
        .DIGITS (DIGITS)
    ) u_bcd (
        .clk   (clk),
        .rst_n (rst_n),
        .step  (step),
        .bcd_q (bcd)
    );

endmodule

// File: rtl/bcd_track_chk.sv
// Module: property checker for the tracking converter.
// Does: watches the ports and the internal count and target over time.
// Assumes: attached to every instance of the top through the bind below.
module bcd_track_chk #(
    parameter int IN_W    = 8,
    parameter int SCALE   = 141,
    parameter int DROP    = 2,
    parameter int DIGITS  = 4,
    parameter int TGT_W   = 14,
    parameter int MAX_TGT = 8988
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [IN_W-1:0]      din,
    input logic [4*DIGITS-1:0]  bcd,
    input logic                 settled,
    input logic [TGT_W-1:0]     bin_cnt,
    input logic [TGT_W-1:0]     tgt
);

    int   bcd_val;
    logic digits_ok;

    // Decimal value spelled by the digits, and whether each is 0..9.
    always_comb begin
        bcd_val   = 0;
        digits_ok = 1'b1;
        for (int i = DIGITS - 1; i >= 0; i--) begin
            bcd_val = bcd_val * 10 + int'(bcd[4*i +: 4]);
            if (bcd[4*i +: 4] > 4'd9) digits_ok = 1'b0;
        end
    end

    // R1: target follows the scaled input one clock later.
    a_r1_target_load: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (int'(tgt) == ((int'($past(din)) * SCALE) >> DROP)));

    // R2: a reset edge leaves everything cleared.
    a_r2_reset_clears: assert property (@(posedge clk)
        !rst_n |=> (bin_cnt == '0 && bcd == '0 && tgt == '0));

    // R3: below target means one step up.
    a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_cnt < tgt) |=> (int'(bin_cnt) == int'($past(bin_cnt)) + 1));

    // R4: above target means one step down.
    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (bin_cnt > tgt) |=> (int'(bin_cnt) == int'($past(bin_cnt)) - 1));

    // R5: a settled count holds on the next edge.
    a_r5_hold: assert property (@(posedge clk) disable iff (!rst_n)
        settled |=> ($stable(bin_cnt) && $stable(bcd)));

    // R6: BCD digits always spell the binary count.
    a_r6_mirror: assert property (@(posedge clk) disable iff (!rst_n)
        bcd_val == int'(bin_cnt));

    // R7: no digit ever leaves 0..9.
    a_r7_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        digits_ok);

    // R9: neither count nor target passes full scale.
    a_r9_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bin_cnt) <= MAX_TGT) && (int'(tgt) <= MAX_TGT));

endmodule

bind bcd_track_conv bcd_track_chk #(
    .IN_W    (IN_W),
    .SCALE   (SCALE),
    .DROP    (DROP),
    .DIGITS  (DIGITS),
    .TGT_W   (TGT_W),
    .MAX_TGT (MAX_TGT)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .din     (din),
    .bcd     (bcd),
    .settled (settled),
    .bin_cnt (bin_q),
    .tgt     (tgt_q)
);

// File: tb/bcd_track_conv_test.sv
module bcd_track_conv_test;

    localparam int CLK_PERIOD = 10;
    localparam int SCALE      = 141;
    localparam int FULL       = 8988;

    logic        clk   = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  din   = 8'd0;
    logic [15:0] bcd;
    logic        settled;

    int n_chk = 0;
    int n_bad = 0;
    bit track = 1'b0;
    int m_cnt = 0;
    int m_tgt = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bcd_track_conv uut (
        .clk     (clk),
        .rst_n   (rst_n),
        .din     (din),
        .bcd     (bcd),
        .settled (settled)
    );

    function automatic int scaled(input int v);
        return (v * SCALE) / 4;
    endfunction

    function automatic logic [15:0] to_bcd(input int v);
        return {4'(v / 1000 % 10), 4'(v / 100 % 10), 4'(v / 10 % 10), 4'(v % 10)};
    endfunction

    function automatic int from_bcd(input logic [15:0] b);
        return int'(b[15:12]) * 1000 + int'(b[11:8]) * 100 + int'(b[7:4]) * 10 + int'(b[3:0]);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Reference count built from R1/R3/R4/R5 and reset from R2.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt <= 0;
            m_tgt <= 0;
        end else begin
            m_tgt <= scaled(int'(din));
            if (m_cnt < m_tgt)      m_cnt <= m_cnt + 1;
            else if (m_cnt > m_tgt) m_cnt <= m_cnt - 1;
        end
    end

    // Per-cycle comparison against the reference (R5, R6, R7).
    always @(negedge clk) begin
        if (rst_n && track) begin
            check(bcd == to_bcd(m_cnt), "R6 digits mirror count", bcd, to_bcd(m_cnt));
            check(settled == (m_cnt == m_tgt), "R5 settled flag", settled, m_cnt == m_tgt);
            check(bcd[3:0] <= 4'd9 && bcd[7:4] <= 4'd9 && bcd[11:8] <= 4'd9 && bcd[15:12] <= 4'd9,
                  "R7 digit range", bcd, 0);
        end
    end

    task automatic wait_settle(input string req, output int cyc);
        cyc = 0;
        repeat (2) begin @(negedge clk); cyc++; end
        while (!settled && cyc < 9200) begin @(negedge clk); cyc++; end
        check(settled, "R9 settle timeout", cyc, 9200);
        check(bcd == to_bcd(scaled(int'(din))), req, bcd, to_bcd(scaled(int'(din))));
    endtask

    initial begin
        repeat (195000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog expired actual=%0h expected=%0h", 1, 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int cyc;
        int v;
        logic [15:0] held;
        void'($urandom(32'd2024));

        // R2: reset state.
        repeat (3) @(negedge clk);
        check(bcd == 16'h0000, "R2 reset digits", bcd, 0);
        check(settled == 1'b1, "R2 reset settled", settled, 1);
        rst_n = 1'b1;
        track = 1'b1;

        // R3: first two upward steps after 0x80 is applied.
        din = 8'h80;
        repeat (3) @(negedge clk);
        check(bcd == 16'h0002 && settled == 1'b0, "R3 step up", bcd, 16'h0002);
        wait_settle("R1 0x80 result", cyc);
        check(bcd == 16'h4512, "R1 0x80 gives 4512", bcd, 16'h4512);

        // R9: full scale from zero.
        @(negedge clk); din = 8'd0;
        wait_settle("R1 zero input", cyc);
        @(negedge clk); din = 8'd255;
        wait_settle("R9 full scale value", cyc);
        check(cyc <= FULL + 2, "R9 full scale time", cyc, FULL + 2);
        check(bcd == 16'h8988, "R9 full scale digits", bcd, 16'h8988);

        // R4: downward steps.
        @(negedge clk); din = 8'd0;
        repeat (3) @(negedge clk);
        check(bcd == 16'h8986, "R4 step down", bcd, 16'h8986);

        // R8: retarget mid-walk keeps the present count.
        repeat (500) @(negedge clk);
        v = from_bcd(bcd);
        din = 8'd64;
        repeat (2) @(negedge clk);
        check(bcd == to_bcd(v - 2), "R8 no restart", bcd, to_bcd(v - 2));
        wait_settle("R1 retarget result", cyc);

        // R7: carry 0999 -> 1000 and borrow 1000 -> 0999.
        @(negedge clk); din = 8'd28;
        wait_settle("R1 input 28", cyc);
        @(negedge clk); din = 8'd29;
        cyc = 0;
        while (bcd != 16'h0999 && cyc < 200) begin @(negedge clk); cyc++; end
        @(negedge clk);
        check(bcd == 16'h1000, "R7 carry ripple", bcd, 16'h1000);
        wait_settle("R1 input 29", cyc);
        @(negedge clk); din = 8'd28;
        cyc = 0;
        while (bcd != 16'h1000 && cyc < 200) begin @(negedge clk); cyc++; end
        @(negedge clk);
        check(bcd == 16'h0999, "R7 borrow ripple", bcd, 16'h0999);
        wait_settle("R1 input 28 again", cyc);

        // R5: settled count holds.
        held = bcd;
        repeat (20) begin
            @(negedge clk);
            check(bcd == held && settled, "R5 hold", bcd, held);
        end

        // Directed small inputs.
        @(negedge clk); din = 8'd1;
        wait_settle("R1 input 1", cyc);
        @(negedge clk); din = 8'd3;
        wait_settle("R1 input 3", cyc);

        // Random inputs.
        for (int i = 0; i < 10; i++) begin
            @(negedge clk); din = 8'($urandom_range(0, 255));
            wait_settle("R1 random input", cyc);
        end

        // R2: reset in the middle of a walk.
        @(negedge clk); din = 8'd200;
        repeat (50) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check(bcd == 16'h0000, "R2 mid-run reset digits", bcd, 0);
        check(settled == 1'b1, "R2 mid-run reset settled", settled, 1);
        rst_n = 1'b1;
        wait_settle("R1 after reset", cyc);

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule